// File: doc/BRIEF.md
# Dual-Channel Measurement Sequencer

The sequencer drives a converter front end through a repeating pattern of two measurement setups, channel A and channel B. Each channel has its own settings word, which can carry its own sampling-rate choice. A shared settings word is passed unchanged to the converter. The shared word's low field sets how many back-to-back conversions each channel gets before the sequencer moves on to the other one. For every conversion the sequencer pulses a start strobe and then waits for the converter's completion strobe. It then stores the converter's 16-bit sample with a channel bit placed above it, and pulls an active-low ready flag down.

Alternation only runs while the dual-mode enable is high. When the enable is low, every conversion uses channel A and the repeat count stays cleared. The converter's internal averaging is enabled only in that single-channel state. Whenever the channel changes, a fixed settling gap, set by a parameter, is inserted before the next start, so that the converter can be reprogrammed.

Top module: `dual_meas_seq`

## Requirements
- R1: During reset `res_rdy_n` is 1, `res_data` is 0 and `conv_start` is 0. The first `conv_start` appears in the second cycle after reset is released, and it uses channel A.
- R2: `conv_start` is a single-cycle pulse. At most one conversion is outstanding at a time, and no new start is issued until `conv_done` has been accepted.
- R3: With `dual_en` high, the channels alternate in runs. Each run has N consecutive conversions, where N is the value of `common_cfg[3:0]`.
- R4: A repeat field of 0 behaves like 1, which gives A, B, A, B.
- R5: `conv_cfg` equals `cfg_b` while channel B is selected and `cfg_a` otherwise. The selected channel does not change between a start and its accepted completion.
- R6: On an accepted `conv_done`, `res_data` becomes {channel, `conv_data`}, with bit 16 equal to 0 for A and 1 for B. `res_rdy_n` goes low on the following cycle.
- R7: `res_rdy_n` returns to 1 the cycle after either `res_rd` or a `conv_start`. If `res_rd` coincides with an accepted `conv_done`, the new result wins and `res_rdy_n` is 0.
- R8: When no channel change happens, the next start follows one cycle after the accepted `conv_done`. When the channel changes, the next start follows after 1 + SWITCH_DLY cycles.
- R9: `conv_avg_en` is 0 for every conversion that starts while alternation is active. It is 1 only for conversions in single-channel operation.
- R10: If `dual_en` is low when a conversion completes, the next conversion uses channel A with the repeat count cleared. While `dual_en` stays low, every conversion uses A.
- R11: A `conv_done` that arrives while no conversion is outstanding, for example during the settling gap, has no effect on `res_data` or `res_rdy_n`.
- R12: `conv_common` always equals `common_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_en | input | 1 | High selects A/B alternation; low selects A only |
| cfg_a | input | 12 | Channel A settings word |
| cfg_b | input | 12 | Channel B settings word |
| common_cfg | input | 12 | Shared settings; bits [3:0] hold the repeat count |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_cfg | output | 12 | Settings word of the selected channel |
| conv_common | output | 12 | Shared settings passed to the converter |
| conv_avg_en | output | 1 | Converter averaging permitted |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 16 | Converter sample, valid with `conv_done` |
| res_rd | input | 1 | Result read strobe |
| res_data | output | 17 | Channel bit (16) and sample (15:0) |
| res_rdy_n | output | 1 | Active-low result-ready flag |

## Verification
Two events can land on the ready flag in the same cycle. A completing conversion pulls it low, and a read strobe pushes it high. The bench causes this collision by asserting `res_rd` in exactly the cycle in which its converter model pulses `conv_done`. One cycle later it requires the flag to be low and the new sample to be present. In a similar way, the bench drives a stray completion into the settling gap, where that strobe competes with the gap countdown, and checks that the stored result is left unchanged.

// File: rtl/dms_pkg.sv
package dms_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_GAP    = 2'd3
    } dms_state_e;

    typedef struct packed {
        dms_state_e st;
        logic       mode;
    } dms_ctl_t;

endpackage

// File: rtl/dms_repeat.sv
module dms_repeat #(
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic             dual_en,
    input  logic [REP_W-1:0] rep_field,
    output logic             ch_o,
    output logic             switch_o
);

    typedef struct packed {
        logic             ch;
        logic [REP_W-1:0] cnt;
    } rep_t;

    rep_t             rep_d, rep_q;
    logic [REP_W-1:0] reps;
    logic             run_end;
    logic             nxt_ch;
    logic [REP_W-1:0] nxt_cnt;

    always_comb begin
        reps    = (rep_field == '0) ? REP_W'(1) : rep_field;
        run_end = ({1'b0, rep_q.cnt} + (REP_W+1)'(1)) >= {1'b0, reps};
        if (!dual_en) begin
            nxt_ch  = 1'b0;
            nxt_cnt = '0;
        end else if (run_end) begin
            nxt_ch  = ~rep_q.ch;
            nxt_cnt = '0;
        end else begin
            nxt_ch  = rep_q.ch;
            nxt_cnt = rep_q.cnt + REP_W'(1);
        end
        switch_o = (nxt_ch != rep_q.ch);
        rep_d    = rep_q;
        if (clear) begin
            rep_d = '0;
        end else if (advance) begin
            rep_d.ch  = nxt_ch;
            rep_d.cnt = nxt_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign ch_o = rep_q.ch;

    // R4: a zero field gives runs of one
    a_r4_zero_field_single: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && dual_en && rep_field == '0) |=> (rep_q.cnt == '0));

    // R10: single-channel completion returns to A
    a_r10_single_back_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !dual_en) |=> (ch_o == 1'b0));

endmodule

// File: rtl/dms_gap_timer.sv
module dms_gap_timer #(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last_o
);

    localparam int DLY_W = (DLY > 0) ? $clog2(DLY + 1) : 1;

    generate
        if (DLY == 0) begin : g_nogap
            assign last_o = 1'b1;
        end else begin : g_gap
            logic [DLY_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (load)                cnt_d = DLY_W'(DLY);
                else if (cnt_q != '0)    cnt_d = cnt_q - DLY_W'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign last_o = (cnt_q == DLY_W'(1));

            // R8: countdown never leaves its range
            a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= DLY_W'(DLY));
        end
    endgenerate

endmodule

// File: rtl/dms_result.sv
module dms_result #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              tag,
    input  logic [DATA_W-1:0] data,
    input  logic              rd,
    input  logic              launch,
    output logic [DATA_W:0]   res_o,
    output logic              rdy_n_o
);

    typedef struct packed {
        logic [DATA_W:0] res;
        logic            rdy_n;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (capture) begin
            out_d.res   = {tag, data};
            out_d.rdy_n = 1'b0;
        end else if (rd || launch) begin
            out_d.rdy_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.res   <= '0;
            out_q.rdy_n <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o   = out_q.res;
    assign rdy_n_o = out_q.rdy_n;

    // R7: a completion outranks a read in the same cycle
    a_r7_done_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && rd) |=> !rdy_n_o);

    // R11: without capture the stored word is held
    a_r11_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(res_o));

endmodule

// File: rtl/dual_meas_seq.sv
module dual_meas_seq
    import dms_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CFG_W      = 12,
    parameter int REP_W      = 4,
    parameter int SWITCH_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_en,
    input  logic [CFG_W-1:0]  cfg_a,
    input  logic [CFG_W-1:0]  cfg_b,
    input  logic [CFG_W-1:0]  common_cfg,
    output logic              conv_start,
    output logic [CFG_W-1:0]  conv_cfg,
    output logic [CFG_W-1:0]  conv_common,
    output logic              conv_avg_en,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              res_rd,
    output logic [DATA_W:0]   res_data,
    output logic              res_rdy_n
);

    localparam bit HAS_GAP = (SWITCH_DLY > 0);

    dms_ctl_t ctl_d, ctl_q;
    logic     ch;
    logic     sw;
    logic     gap_last;
    logic     accept;
    logic     clear;
    logic     load;

    always_comb begin
        ctl_d  = ctl_q;
        accept = 1'b0;
        clear  = 1'b0;
        load   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                clear      = 1'b1;
                ctl_d.mode = dual_en;
                ctl_d.st   = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done) begin
                    accept     = 1'b1;
                    ctl_d.mode = dual_en;
                    if (sw && HAS_GAP) begin
                        load     = 1'b1;
                        ctl_d.st = ST_GAP;
                    end else begin
                        ctl_d.st = ST_LAUNCH;
                    end
                end
            end
            ST_GAP: begin
                if (gap_last) ctl_d.st = ST_LAUNCH;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.mode <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dms_repeat #(.REP_W(REP_W)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .advance  (accept),
        .dual_en  (dual_en),
        .rep_field(common_cfg[REP_W-1:0]),
        .ch_o     (ch),
        .switch_o (sw)
    );

    dms_gap_timer #(.DLY(SWITCH_DLY)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .last_o(gap_last)
    );

    dms_result #(.DATA_W(DATA_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(accept),
        .tag    (ch),
        .data   (conv_data),
        .rd     (res_rd),
        .launch (conv_start),
        .res_o  (res_data),
        .rdy_n_o(res_rdy_n)
    );

    assign conv_start  = (ctl_q.st == ST_LAUNCH);
    assign conv_cfg    = ch ? cfg_b : cfg_a;
    assign conv_common = common_cfg;
    assign conv_avg_en = ~ctl_q.mode;

    // R2: start is a lone pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R5: channel frozen while a conversion is outstanding
    a_r5_ch_stable_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && !conv_done) |=> $stable(ch));

    // R6: accepted completion lowers ready
    a_r6_done_lowers_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && conv_done) |=> !res_rdy_n);

    // R7: a start raises ready
    a_r7_start_raises_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> res_rdy_n);

    // R9: channel B is never converted with averaging
    a_r9_b_never_avg: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && ch) |-> !conv_avg_en);

    // R10: single-channel conversions use A
    a_r10_single_is_a: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_avg_en) |-> !ch);

endmodule

// File: tb/sim_dual_meas_seq.sv
module sim_dual_meas_seq;

    localparam int DW = 16;
    localparam int CW = 12;
    localparam int GD = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dual_en = 1'b1;
    logic [CW-1:0] cfg_a = 12'h3C1;
    logic [CW-1:0] cfg_b = 12'h5B7;
    logic [CW-1:0] common_cfg = 12'h0A2;
    logic          conv_start;
    logic [CW-1:0] conv_cfg;
    logic [CW-1:0] conv_common;
    logic          conv_avg_en;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          res_rd = 1'b0;
    logic [DW:0]   res_data;
    logic          res_rdy_n;

    dual_meas_seq #(.DATA_W(DW), .CFG_W(CW), .REP_W(4), .SWITCH_DLY(GD)) u0 (
        .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .common_cfg(common_cfg), .conv_start(conv_start), .conv_cfg(conv_cfg),
        .conv_common(conv_common), .conv_avg_en(conv_avg_en), .conv_done(conv_done),
        .conv_data(conv_data), .res_rd(res_rd), .res_data(res_data), .res_rdy_n(res_rdy_n)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int n_res = 0;
    int cyc   = 0;
    bit done_flag = 0;

    // stimulus knobs written after posedges, read at negedges
    bit            g_dual = 1;
    logic [CW-1:0] g_common = 12'h0A2;
    int            g_lat = 3;
    bit            g_rd_auto = 1;
    bit            g_rd_with_done = 0;
    bit            g_stray = 0;

    // reference model state
    int          mst, mgap, mcnt, pend;
    bit          mch, mmode, mrdy, prev_rdy;
    logic [DW:0] mres;
    bit          hz_chk, stray_chk;
    logic [DW:0] stray_ref;
    bit          tags[$];

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        bit          d, rd;
        logic [DW-1:0] dat;
        int          reps;
        bit          nch;
        int          ncnt;
        cyc++;
        if (cyc > 150000) begin
            chk(0, "R2 watchdog expired", 0, 1);
            finish_run();
        end
        if (!rst_n) begin
            mst = 0; mgap = 0; mcnt = 0; pend = 0; mch = 0; mmode = 0;
            mrdy = 1; mres = '0; prev_rdy = 1; hz_chk = 0; stray_chk = 0;
            conv_done = 0; res_rd = 0;
        end else begin
            // compare current cycle against the model
            chk(conv_start === (mst == 1), "R8 conv_start", 32'(conv_start), 32'(mst == 1));
            chk(conv_cfg === (mch ? cfg_b : cfg_a), "R5 conv_cfg", 32'(conv_cfg),
                32'(mch ? cfg_b : cfg_a));
            chk(conv_avg_en === !mmode, "R9 conv_avg_en", 32'(conv_avg_en), 32'(!mmode));
            chk(res_data === mres, "R6 res_data", 32'(res_data), 32'(mres));
            chk(res_rdy_n === mrdy, "R7 res_rdy_n", 32'(res_rdy_n), 32'(mrdy));
            chk(conv_common === common_cfg, "R12 conv_common", 32'(conv_common),
                32'(common_cfg));
            if (hz_chk) begin
                chk(res_rdy_n === 1'b0, "R7 read vs completion", 32'(res_rdy_n), 0);
                hz_chk = 0;
            end
            if (stray_chk) begin
                chk(res_data === stray_ref, "R11 stray done ignored", 32'(res_data),
                    32'(stray_ref));
                stray_chk = 0;
            end
            if (prev_rdy && !res_rdy_n) begin
                tags.push_back(res_data[DW]);
                n_res++;
            end
            prev_rdy = res_rdy_n;

            // converter model and inputs for this cycle
            d = 0; dat = 16'($urandom);
            if (conv_start) pend = g_lat;
            else if (pend > 0) begin
                pend--;
                if (pend == 0) d = 1;
            end else if (g_stray && mst == 3) begin
                d = 1; dat = 16'hDEAD; g_stray = 0;
                stray_chk = 1; stray_ref = res_data;
            end
            rd = (g_rd_auto && !res_rdy_n) || (g_rd_with_done && d && !stray_chk);
            if (d && rd && !stray_chk) hz_chk = 1;
            conv_done = d; conv_data = dat; res_rd = rd;
            dual_en = g_dual; common_cfg = g_common;

            // advance the model to the next cycle
            if (mst == 2 && d) begin
                mres = {mch, dat}; mrdy = 0;
            end else if (rd || mst == 1) begin
                mrdy = 1;
            end
            case (mst)
                0: begin mch = 0; mcnt = 0; mmode = g_dual; mst = 1; end
                1: mst = 2;
                2: if (d) begin
                    reps = (g_common[3:0] == 0) ? 1 : int'(g_common[3:0]);
                    if (!g_dual) begin nch = 0; ncnt = 0; end
                    else if (mcnt + 1 >= reps) begin nch = !mch; ncnt = 0; end
                    else begin nch = mch; ncnt = mcnt + 1; end
                    mmode = g_dual;
                    if (nch != mch && GD > 0) begin mgap = GD; mst = 3; end
                    else mst = 1;
                    mch = nch; mcnt = ncnt;
                end
                default: begin
                    if (mgap == 1) mst = 1;
                    else mgap--;
                end
            endcase
        end
    end

    task automatic wait_results(input int n);
        int target = n_res + n;
        while (n_res < target) @(posedge clk);
    endtask

    task automatic check_runs(input int n, input string what);
        int lens[$];
        int run = 1;
        for (int i = 1; i < tags.size(); i++) begin
            if (tags[i] == tags[i-1]) run++;
            else begin lens.push_back(run); run = 1; end
        end
        chk(lens.size() >= 3, {what, " run count"}, 32'(lens.size()), 3);
        for (int i = 1; i < lens.size(); i++)
            chk(lens[i] == n, {what, " run length"}, 32'(lens[i]), 32'(n));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(res_rdy_n === 1'b1, "R1 rdy in reset", 32'(res_rdy_n), 1);
        chk(res_data === '0, "R1 res in reset", 32'(res_data), 0);
        chk(conv_start === 1'b0, "R1 start in reset", 32'(conv_start), 0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk); @(negedge clk);
        chk(conv_start === 1'b1, "R1 first start", 32'(conv_start), 1);
        chk(conv_cfg === cfg_a, "R1 first channel", 32'(conv_cfg), 32'(cfg_a));

        // R3: runs of two
        @(posedge clk); tags.delete();
        wait_results(12);
        check_runs(2, "R3 field=2");

        // R3: runs of three, other settings words
        @(posedge clk); g_common = 12'h7E3; cfg_a = 12'h0F0; cfg_b = 12'hA05; g_lat = 5;
        wait_results(4); tags.delete();
        wait_results(16);
        check_runs(3, "R3 field=3");

        // R4: zero field alternates every conversion
        @(posedge clk); g_common = 12'h150;
        wait_results(3); tags.delete();
        wait_results(10);
        check_runs(1, "R4 field=0");

        // R10: single-channel operation
        @(posedge clk); g_dual = 0;
        wait_results(2); tags.delete();
        wait_results(6);
        foreach (tags[i]) chk(tags[i] == 0, "R10 single uses A", 32'(tags[i]), 0);

        // back to alternation, fast converter, reads left to starts
        @(posedge clk); g_dual = 1; g_common = 12'h001; g_lat = 1; g_rd_auto = 0;
        wait_results(8);

        // R7: read strobe coinciding with completion
        @(posedge clk); g_rd_with_done = 1; g_lat = 4;
        wait_results(4);
        @(posedge clk); g_rd_with_done = 0; g_rd_auto = 1;

        // R11: completion strobe during the settling gap
        @(posedge clk); g_common = 12'h002; g_stray = 1;
        while (g_stray) @(posedge clk);
        wait_results(4);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule